// File: doc/BRIEF.md
# I2C SCL Phase Timer

This block sets the timing of the serial clock for an I2C bus master. Two programmable counts, both in peripheral clock cycles, give the length of the low phase and of the high phase of SCL separately. Each count is eight bits wide in its own register. A ninth, most significant bit for each count is taken from a fixed bit of the master's interrupt-enable register. The host is expected to split the bus period roughly 5:4 between low and high, for example for 100 kHz or 400 kHz operation, and computes the counts itself.

The byte engine controls the timer through three inputs. `run` asks for clock periods. `hold` freezes the timer in the low phase, for example while the engine waits on software. `en` gates the whole channel. The timer drives a released or low SCL level. It marks the first cycle of each low phase and of each high phase with a strobe. It also gives a mid-low pulse at which the engine changes SDA and a mid-high pulse at which it samples SDA. The high phase is counted only while the SCL line actually reads high, so a slave that stretches the clock lengthens the high phase.

Top module: `scl_period_gen`

## Requirements
- R1: During and straight after reset, `scl_out` is 1 (released) and all four strobes are 0.
- R2: The low phase lasts N cycles, where N is the 9-bit value {`ien_reg[7]`, `low_cnt`}. A value of zero counts as 1. The other `ien_reg` bits have no effect.
- R3: The high phase lasts M cycles with SCL reading high, where M is the 9-bit value {`ien_reg[6]`, `high_cnt`}. A value of zero counts as 1.
- R4: From idle, with `en`, `run` and `scl_in` all at 1 in a cycle, SCL is driven low in the next cycle. While `scl_in` reads 0 in idle, no low phase starts.
- R5: `fall_stb` is 1 only in the first cycle of a low phase, and `rise_stb` is 1 only in the first cycle of a high phase. The two are never 1 together.
- R6: Each cycle of `hold` during a low phase, after its first cycle, lengthens that low phase by one cycle.
- R7: While `scl_in` reads 0 during a high phase, `scl_out` stays released and the high count does not advance. Each such cycle lengthens the high phase by one.
- R8: `launch_stb` pulses once per low phase, in the cycle where floor(N/2) non-held cycles of that phase have elapsed. It pulses only while SCL is driven low.
- R9: `sample_stb` pulses once per high phase, in the cycle where floor(M/2) cycles with SCL high have elapsed. It pulses only while `scl_in` reads 1.
- R10: If `run` is 1 at the end of a high phase, the next low phase starts in the following cycle, so the period is N+M. If `run` is 0, the timer goes idle and SCL stays released.
- R11: `en` at 0 in any cycle returns the timer to idle, with SCL released, from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Channel enable |
| run | input | 1 | Byte engine requests further clock periods |
| hold | input | 1 | Freeze in the low phase |
| low_cnt | input | 8 | Low phase count, bits 7:0 |
| high_cnt | input | 8 | High phase count, bits 7:0 |
| ien_reg | input | 8 | Interrupt-enable register image; bit 7 and bit 6 extend the counts |
| scl_in | input | 1 | Level read back from the SCL line |
| scl_out | output | 1 | SCL drive: 0 pulls low, 1 releases |
| fall_stb | output | 1 | First cycle of a low phase |
| rise_stb | output | 1 | First cycle of a high phase |
| launch_stb | output | 1 | Mid-low point: change SDA |
| sample_stb | output | 1 | Mid-high point: sample SDA |

## Verification
The properties assume that `scl_in` behaves like a wired-AND line: it never reads high while the block pulls SCL low. They also assume that `hold` matters only inside a low phase. The stimulus builds `scl_in` as the AND of `scl_out` and a bench stretch term. It raises `hold` only from the second cycle of a low phase of at least two cycles, and raises the stretch term only from the second cycle of a high phase of at least two cycles. It changes the counts and `ien_reg` only while the timer is idle. Under these conditions each phase length and strobe offset has a closed form that the scoreboard predicts.

// File: rtl/sclg_pkg.sv
`timescale 1ns/1ps
package sclg_pkg;

    // Bus clock phase the timer is in.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    // Command from the phase sequencer to the shared counter.
    typedef struct packed {
        logic clr;
        logic adv;
    } ctr_cmd_t;

    localparam ctr_cmd_t CMD_NONE = '{clr: 1'b0, adv: 1'b0};
    localparam ctr_cmd_t CMD_CLR  = '{clr: 1'b1, adv: 1'b0};
    localparam ctr_cmd_t CMD_ADV  = '{clr: 1'b0, adv: 1'b1};

endpackage

// File: rtl/sclg_len_sel.sv
`timescale 1ns/1ps
// Joins the borrowed top bit to an 8-bit count and maps zero to one.
module sclg_len_sel #(
    parameter int CNT_W = 8,
    localparam int LEN_W = CNT_W + 1
) (
    input  logic [CNT_W-1:0] base,
    input  logic             ext_msb,
    output logic [LEN_W-1:0] len
);
    logic [LEN_W-1:0] raw;

    always_comb begin
        raw = {ext_msb, base};
        len = (raw == '0) ? LEN_W'(1) : raw;
    end
endmodule

// File: rtl/sclg_counter.sv
`timescale 1ns/1ps
// One counter shared by both phases; the sequencer clears it at every phase entry.
module sclg_counter
    import sclg_pkg::*;
#(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  ctr_cmd_t     cmd,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cmd.clr) begin
            cnt <= '0;
        end else if (cmd.adv) begin
            cnt <= cnt + W'(1);
        end
    end
endmodule

// File: rtl/sclg_fsm.sv
`timescale 1ns/1ps
// Phase sequencer: walks idle/low/high and latches the active phase length.
module sclg_fsm
    import sclg_pkg::*;
#(
    parameter int LW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          run,
    input  logic          hold,
    input  logic          scl_in,
    input  logic [LW-1:0] cnt,
    input  logic [LW-1:0] low_len,
    input  logic [LW-1:0] high_len,
    output ctr_cmd_t      cmd,
    output phase_e        phase,
    output logic [LW-1:0] len_q,
    output logic          fall_stb,
    output logic          rise_stb
);
    phase_e nxt;
    logic   load_lo;
    logic   load_hi;
    logic   fall_n;
    logic   rise_n;
    logic   last;

    always_comb begin
        nxt     = phase;
        cmd     = CMD_NONE;
        load_lo = 1'b0;
        load_hi = 1'b0;
        fall_n  = 1'b0;
        rise_n  = 1'b0;
        last    = (cnt == (len_q - LW'(1)));
        unique case (phase)
            PH_IDLE: begin
                // Start only when the line is really free.
                if (en && run && scl_in) begin
                    nxt     = PH_LOW;
                    cmd     = CMD_CLR;
                    load_lo = 1'b1;
                    fall_n  = 1'b1;
                end
            end
            PH_LOW: begin
                if (!en) begin
                    nxt = PH_IDLE;
                    cmd = CMD_CLR;
                end else if (!hold) begin
                    if (last) begin
                        nxt     = PH_HIGH;
                        cmd     = CMD_CLR;
                        load_hi = 1'b1;
                        rise_n  = 1'b1;
                    end else begin
                        cmd = CMD_ADV;
                    end
                end
            end
            PH_HIGH: begin
                if (!en) begin
                    nxt = PH_IDLE;
                    cmd = CMD_CLR;
                end else if (scl_in) begin
                    // A stretching slave keeps scl_in low: no advance.
                    if (last) begin
                        cmd = CMD_CLR;
                        if (run) begin
                            nxt     = PH_LOW;
                            load_lo = 1'b1;
                            fall_n  = 1'b1;
                        end else begin
                            nxt = PH_IDLE;
                        end
                    end else begin
                        cmd = CMD_ADV;
                    end
                end
            end
            default: begin
                nxt = PH_IDLE;
                cmd = CMD_CLR;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            len_q    <= LW'(1);
            fall_stb <= 1'b0;
            rise_stb <= 1'b0;
        end else begin
            phase <= nxt;
            if (load_lo) begin
                len_q <= low_len;
            end else if (load_hi) begin
                len_q <= high_len;
            end
            fall_stb <= fall_n;
            rise_stb <= rise_n;
        end
    end
endmodule

// File: rtl/scl_period_gen.sv
`timescale 1ns/1ps
module scl_period_gen
    import sclg_pkg::*;
#(
    parameter int CNT_W        = 8,
    parameter int IE_W         = 8,
    parameter int LOW_EXT_BIT  = 7,
    parameter int HIGH_EXT_BIT = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             run,
    input  logic             hold,
    input  logic [CNT_W-1:0] low_cnt,
    input  logic [CNT_W-1:0] high_cnt,
    input  logic [IE_W-1:0]  ien_reg,
    input  logic             scl_in,
    output logic             scl_out,
    output logic             fall_stb,
    output logic             rise_stb,
    output logic             launch_stb,
    output logic             sample_stb
);
    localparam int LEN_W  = CNT_W + 1;
    localparam int N_PH   = 2;

    logic [LEN_W-1:0] ph_len [N_PH];
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] mid;
    ctr_cmd_t         cmd;
    phase_e           phase;
    logic             unused_ie_bits;

    // Only two bits of the register image are consumed.
    assign unused_ie_bits = ^ien_reg;

    // Index 0 = low phase, index 1 = high phase.
    for (genvar gi = 0; gi < N_PH; gi++) begin : g_len
        sclg_len_sel #(
            .CNT_W (CNT_W)
        ) u_len (
            .base    ((gi == 0) ? low_cnt : high_cnt),
            .ext_msb ((gi == 0) ? ien_reg[LOW_EXT_BIT] : ien_reg[HIGH_EXT_BIT]),
            .len     (ph_len[gi])
        );
    end

    sclg_fsm #(
        .LW (LEN_W)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .run      (run),
        .hold     (hold),
        .scl_in   (scl_in),
        .cnt      (cnt),
        .low_len  (ph_len[0]),
        .high_len (ph_len[1]),
        .cmd      (cmd),
        .phase    (phase),
        .len_q    (len_q),
        .fall_stb (fall_stb),
        .rise_stb (rise_stb)
    );

    sclg_counter #(
        .W (LEN_W)
    ) u_ctr (
        .clk (clk),
        .rst (rst),
        .cmd (cmd),
        .cnt (cnt)
    );

    always_comb begin
        mid        = len_q >> 1;
        scl_out    = (phase != PH_LOW);
        launch_stb = (phase == PH_LOW)  && en && !hold  && (cnt == mid);
        sample_stb = (phase == PH_HIGH) && en && scl_in && (cnt == mid);
    end
endmodule

// File: rtl/sclg_checker.sv
`timescale 1ns/1ps
module sclg_checker (
    input logic clk,
    input logic rst,
    input logic en,
    input logic run,
    input logic hold,
    input logic scl_in,
    input logic scl_out,
    input logic fall_stb,
    input logic rise_stb,
    input logic launch_stb,
    input logic sample_stb
);
    a_r5_edge_strobes_apart: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fall_stb, rise_stb}))
        else $error("R5 fall and rise strobes together");

    a_r5_fall_means_low: assert property (@(posedge clk) disable iff (rst)
        fall_stb |-> !scl_out)
        else $error("R5 fall strobe while released");

    a_r5_low_entry_marked: assert property (@(posedge clk) disable iff (rst)
        $fell(scl_out) |-> fall_stb)
        else $error("R5 low phase entered without strobe");

    a_r5_rise_means_high: assert property (@(posedge clk) disable iff (rst)
        rise_stb |-> scl_out)
        else $error("R5 rise strobe while low");

    a_r6_hold_keeps_low: assert property (@(posedge clk) disable iff (rst)
        (en && hold && !scl_out) |=> !scl_out)
        else $error("R6 low phase left during hold");

    a_r7_stretch_keeps_high: assert property (@(posedge clk) disable iff (rst)
        (scl_out && !scl_in) |=> scl_out)
        else $error("R7 SCL pulled low while line reads low");

    a_r4_no_request_no_low: assert property (@(posedge clk) disable iff (rst)
        (scl_out && !(en && run)) |=> scl_out)
        else $error("R4 low phase without request");

    a_r11_disable_releases: assert property (@(posedge clk) disable iff (rst)
        !en |=> (scl_out && !fall_stb))
        else $error("R11 not released after disable");

    a_r8_launch_in_low: assert property (@(posedge clk) disable iff (rst)
        launch_stb |-> !scl_out)
        else $error("R8 launch outside low phase");

    a_r9_sample_when_high: assert property (@(posedge clk) disable iff (rst)
        sample_stb |-> (scl_out && scl_in))
        else $error("R9 sample while line low");
endmodule

bind scl_period_gen sclg_checker u_sclg_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .run        (run),
    .hold       (hold),
    .scl_in     (scl_in),
    .scl_out    (scl_out),
    .fall_stb   (fall_stb),
    .rise_stb   (rise_stb),
    .launch_stb (launch_stb),
    .sample_stb (sample_stb)
);

// File: tb/scl_period_gen_bench.sv
`timescale 1ns/1ps
module scl_period_gen_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b1;
    logic       run = 1'b0;
    logic       hold = 1'b0;
    logic       stretch = 1'b0;
    logic [7:0] lo = 8'd4;
    logic [7:0] hi = 8'd4;
    logic [7:0] ie = 8'd0;
    logic       scl_in;
    logic       scl_out, fall_stb, rise_stb, launch_stb, sample_stb;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    // Wired-AND line: the bench may hold it low to stretch the clock.
    assign scl_in = scl_out & ~stretch;

    scl_period_gen u_scl_period_gen (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .run        (run),
        .hold       (hold),
        .low_cnt    (lo),
        .high_cnt   (hi),
        .ien_reg    (ie),
        .scl_in     (scl_in),
        .scl_out    (scl_out),
        .fall_stb   (fall_stb),
        .rise_stb   (rise_stb),
        .launch_stb (launch_stb),
        .sample_stb (sample_stb)
    );

    // Scoreboard item kinds.
    localparam int K_LAUNCH = 0;
    localparam int K_LOWLEN = 1;
    localparam int K_SAMPLE = 2;
    localparam int K_HIGHLEN = 3;

    typedef struct {
        int    kind;
        int    val;
        string req;
    } exp_t;

    exp_t sb_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic string kname(input int k);
        case (k)
            K_LAUNCH: return "launch offset";
            K_LOWLEN: return "low length";
            K_SAMPLE: return "sample offset";
            default:  return "high length";
        endcase
    endfunction

    task automatic pop_cmp(input int kind, input int act);
        exp_t it;
        if (sb_q.size() == 0) begin
            chk(1'b0, "R5", {"unexpected ", kname(kind)}, act, -1);
        end else begin
            it = sb_q.pop_front();
            chk(it.kind == kind && it.val == act, it.req, kname(kind), act, it.val);
        end
    endtask

    // Monitor: measures phases in wall cycles, sampled at the falling edge.
    bit in_low = 1'b0;
    bit in_high = 1'b0;
    int lidx = 0;
    int hidx = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (in_low)  lidx++;
            if (in_high) hidx++;
            if (fall_stb) begin
                if (in_high) pop_cmp(K_HIGHLEN, hidx);
                in_high = 1'b0;
                in_low  = 1'b1;
                lidx    = 0;
            end
            if (launch_stb && in_low) pop_cmp(K_LAUNCH, lidx);
            if (rise_stb) begin
                pop_cmp(K_LOWLEN, lidx);
                in_low  = 1'b0;
                in_high = 1'b1;
                hidx    = 0;
            end
            if (sample_stb && in_high) pop_cmp(K_SAMPLE, hidx);
        end
    end

    function automatic int eff(input bit msb, input logic [7:0] b);
        int v;
        v = {23'd0, msb, b};
        return (v == 0) ? 1 : v;
    endfunction

    // Driver: predicts a burst of n periods, then plays it.
    // k hold cycles from the second low cycle, s stretch cycles from the second high cycle.
    task automatic burst(input logic [7:0] l8, input logic [7:0] h8, input logic [7:0] ie8,
                         input int n, input int k, input int s);
        int l_len, h_len, l_mid, h_mid;
        l_len = eff(ie8[7], l8);
        h_len = eff(ie8[6], h8);
        l_mid = l_len / 2;
        h_mid = h_len / 2;
        for (int p = 0; p < n; p++) begin
            sb_q.push_back('{K_LAUNCH, l_mid + ((l_mid >= 1) ? k : 0), "R8"});
            sb_q.push_back('{K_LOWLEN, l_len + k, (k > 0) ? "R6" : "R2"});
            sb_q.push_back('{K_SAMPLE, h_mid + ((h_mid >= 1) ? s : 0), "R9"});
            if (p < n - 1)
                sb_q.push_back('{K_HIGHLEN, h_len + s, (s > 0) ? "R7" : "R10"});
        end
        @(posedge clk); #1;
        lo = l8; hi = h8; ie = ie8; run = 1'b1;
        for (int p = 0; p < n; p++) begin
            if (p == 0) begin
                @(negedge clk);
                chk(!fall_stb && scl_out, "R4", "low before one cycle", {31'd0, fall_stb}, 0);
                @(negedge clk);
                chk(fall_stb && !scl_out, "R4", "fall one cycle after request", {31'd0, fall_stb}, 1);
            end else begin
                do @(negedge clk); while (!fall_stb);
            end
            @(posedge clk); #1;
            if (p == n - 1) run = 1'b0;
            if (k > 0) begin
                hold = 1'b1;
                repeat (k) @(posedge clk);
                #1 hold = 1'b0;
            end
            do @(negedge clk); while (!rise_stb);
            @(posedge clk); #1;
            if (s > 0) begin
                stretch = 1'b1;
                repeat (s) @(posedge clk);
                #1 stretch = 1'b0;
            end
        end
        repeat (h_len + s + 4) @(negedge clk);
        chk(sb_q.size() == 0, "R10", "items left after burst", sb_q.size(), 0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(scl_out && !fall_stb, "R10", "idle after run drop", {31'd0, scl_out}, 1);
        end
        in_low = 1'b0;
        in_high = 1'b0;
        sb_q.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(scl_out && !fall_stb && !rise_stb && !launch_stb && !sample_stb,
            "R1", "outputs in reset", {31'd0, scl_out}, 1);
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        chk(scl_out && !fall_stb && !rise_stb && !launch_stb && !sample_stb,
            "R1", "outputs after reset", {31'd0, scl_out}, 1);

        // 5:4 split, continuous periods (R2, R3, R8, R9, R10)
        burst(8'd10, 8'd8, 8'h00, 3, 0, 0);
        // zero counts act as one (R2, R3)
        burst(8'd0, 8'd0, 8'h00, 3, 0, 0);
        // both borrowed bits, other register bits set too (R2, R3)
        burst(8'd2, 8'd1, 8'hFF, 2, 0, 0);
        // only the low count's borrowed bit (R2)
        burst(8'd3, 8'd2, 8'h80, 2, 0, 0);
        // odd lengths and a one-cycle high phase (R8, R9)
        burst(8'd7, 8'd1, 8'h00, 3, 0, 0);
        // hold in the low phase (R6)
        burst(8'd6, 8'd4, 8'h00, 2, 3, 0);
        // slave stretch in the high phase (R7)
        burst(8'd5, 8'd4, 8'h00, 2, 0, 5);

        // line held low while idle: no start (R4)
        @(posedge clk); #1;
        stretch = 1'b1; run = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(scl_out && !fall_stb, "R4", "start while line low", {31'd0, fall_stb}, 0);
        end
        @(posedge clk); #1;
        run = 1'b0; stretch = 1'b0;

        // disable in the middle of a low phase (R11)
        @(posedge clk); #1;
        lo = 8'd20; hi = 8'd20; ie = 8'h00; run = 1'b1;
        do @(negedge clk); while (!fall_stb);
        repeat (3) @(negedge clk);
        @(posedge clk); #1 en = 1'b0;
        @(negedge clk);
        chk(!scl_out, "R11", "still low in disable cycle", {31'd0, scl_out}, 0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(scl_out && !fall_stb && !rise_stb, "R11", "released after disable",
                {31'd0, scl_out}, 1);
        end
        @(posedge clk); #1;
        run = 1'b0; en = 1'b1;
        in_low = 1'b0;
        in_high = 1'b0;
        repeat (4) @(negedge clk);
        chk(sb_q.size() == 0, "R5", "stray scoreboard items", sb_q.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule